// File: doc/BRIEF.md
# Bipolar Receive Decoder with Line-Code Violation Detection

This block sits behind a bipolar line receiver. On each recovered-clock cycle it takes one symbol as two rail bits: a positive-pulse rail and a negative-pulse rail. It tracks the polarity of the marks. A mark that alternates with the previous mark is an ordinary bipolar pulse. A mark that repeats the previous polarity is a violation pulse. From this the block rebuilds the binary NRZ stream. To do so it removes the zero-substitution groups of the selected code, which are three-symbol groups for the 44.736/51.84 Mbit/s code and four-symbol groups for the 34.368 Mbit/s code.

While it decodes, the block also checks the line for malformed coding and marks each offending symbol with a one-cycle flag. The checks cover runs of zeros that are too long, a violation pulse that comes too soon after a bipolar pulse, and an even count of bipolar pulses between two violation pulses. The flag leaves on the output that carries the negative rail in bypass mode. In bypass mode the two rails pass through one register stage without change, for an external decoder.

Top module: `bipolar_rx_decoder`

## Requirements
- R1: With `bypass_i` high, `nrz_o` and `lcv_o` show the values that `rail_p_i` and `rail_n_i` had at the previous rising clock edge.
- R2: With `bypass_i` low, each symbol decodes to one NRZ bit. A mark gives 1 and an empty symbol gives 0. The bit appears on `nrz_o` after the third rising edge in the three-symbol-group mode (`hdb3_sel_i`=0) and after the fourth rising edge in the four-symbol-group mode (`hdb3_sel_i`=1), counting the edge that samples the symbol.
- R3: The zero that makes a run of consecutive empty symbols reach 3 (`hdb3_sel_i`=0) or 4 (`hdb3_sel_i`=1) carries the violation flag. Only that zero is flagged in the run.
- R4: A violation pulse that comes directly after an ordinary bipolar pulse is flagged, in both modes.
- R5: In the four-symbol-group mode, a violation pulse that follows the pattern bipolar pulse then one zero is also flagged.
- R6: A violation pulse is flagged when an even number of ordinary bipolar pulses (zero included) arrived since the previous violation pulse. The first violation pulse after reset is not checked.
- R7: A symbol with both rails high is flagged and decodes to 1. It does not change the tracked polarity or the pulse count.
- R8: In the three-symbol-group mode, a violation pulse that comes after exactly one zero decodes to 0. If the symbol before that zero was an ordinary bipolar pulse, that symbol also decodes to 0.
- R9: In the four-symbol-group mode, a violation pulse that comes after two zeros decodes to 0. If the symbol before those zeros was an ordinary bipolar pulse, that symbol also decodes to 0.
- R10: While `rst` is high at a rising edge, both outputs are 0 after that edge, and the decoder forgets all history.
- R11: The first mark after reset always counts as an ordinary bipolar pulse, whatever its polarity.
- R12: With `bypass_i` low, `lcv_o` is high for exactly the output cycle of each flagged symbol. It is aligned with that symbol's bit on `nrz_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous reset, active high |
| rail_p_i | input | 1 | Positive-pulse rail |
| rail_n_i | input | 1 | Negative-pulse rail |
| hdb3_sel_i | input | 1 | 0: three-symbol substitution code; 1: four-symbol substitution code |
| bypass_i | input | 1 | 1: pass rails through; 0: decode |
| nrz_o | output | 1 | Decoded NRZ data, or positive rail in bypass |
| lcv_o | output | 1 | Violation flag, or negative rail in bypass |

## Verification
The bench builds the block with its default parameters. The window is four slots deep, which is the longest substitution group. The zero-run counter is three bits wide, which holds a run one longer than the four-zero limit. These values bring the late tap of the four-symbol code within reach, and so is the erasure of its oldest slot, and the saturating counter when it holds at its ceiling during long zero runs. Each mode is run from reset with hand-built symbol strings for each substitution and violation class, then with a long pseudo-random symbol stream. That stream crosses every rule with every other, and includes back-to-back violation pulses and dual-rail marks next to substitution groups.

// File: rtl/bprx_pkg.sv
`timescale 1ns/1ps
package bprx_pkg;

    // Classified line symbol
    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_BIP  = 2'd1,
        SYM_VIOL = 2'd2,
        SYM_DUAL = 2'd3
    } sym_e;

    // One slot of the output delay window
    typedef struct packed {
        logic dat;
        logic flag;
    } slot_t;

    // Substitution group lengths (these fix the output taps)
    localparam int B3_GRP = 3;
    localparam int HD_GRP = 4;

    // Largest legal run of zeros for the selected code
    function automatic int zero_limit(input logic hdb3);
        return hdb3 ? (HD_GRP - 1) : (B3_GRP - 1);
    endfunction

endpackage

// File: rtl/bprx_polarity.sv
`timescale 1ns/1ps
module bprx_polarity
    import bprx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pos_i,
    input  logic neg_i,
    output sym_e sym_o
);
    logic seen_q;
    logic last_neg_q;
    logic single;

    assign single = pos_i ^ neg_i;

    always_comb begin
        if (pos_i && neg_i)
            sym_o = SYM_DUAL;
        else if (!single)
            sym_o = SYM_ZERO;
        else if (!seen_q || (neg_i != last_neg_q))
            sym_o = SYM_BIP;
        else
            sym_o = SYM_VIOL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q     <= 1'b0;
            last_neg_q <= 1'b0;
        end else if (single) begin
            seen_q     <= 1'b1;
            last_neg_q <= neg_i;
        end
    end

    // R11: right after reset, a single-rail mark is never a violation
    p_first_mark_bip_r11: assert property (@(posedge clk) disable iff (rst)
        (!seen_q && single) |-> (sym_o == SYM_BIP));

endmodule

// File: rtl/bprx_rules.sv
`timescale 1ns/1ps
module bprx_rules
    import bprx_pkg::*;
#(
    parameter int ZCNT_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic hdb3_i,
    input  sym_e sym_i,
    output logic flag_o,
    output logic sub_o,
    output logic erase_o
);
    localparam int HIST = HD_GRP - 1;

    sym_e              hist_q [HIST];
    logic [ZCNT_W-1:0] zrun_q;
    logic              par_odd_q;
    logic              seen_v_q;
    logic [ZCNT_W-1:0] lim;
    logic              zero_flag, near_flag, par_flag, dual_flag;
    sym_e              oldest;

    assign lim = ZCNT_W'(zero_limit(hdb3_i));

    always_comb begin
        zero_flag = (sym_i == SYM_ZERO) && (zrun_q == lim);
        near_flag = (sym_i == SYM_VIOL) &&
                    ((hist_q[0] == SYM_BIP) ||
                     (hdb3_i && hist_q[0] == SYM_ZERO && hist_q[1] == SYM_BIP));
        par_flag  = (sym_i == SYM_VIOL) && seen_v_q && !par_odd_q;
        dual_flag = (sym_i == SYM_DUAL);
        flag_o    = zero_flag | near_flag | par_flag | dual_flag;
        sub_o     = (sym_i == SYM_VIOL) && (hist_q[0] == SYM_ZERO) &&
                    (!hdb3_i || hist_q[1] == SYM_ZERO);
        oldest    = hdb3_i ? hist_q[2] : hist_q[1];
        erase_o   = sub_o && (oldest == SYM_BIP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HIST; i++) hist_q[i] <= SYM_ZERO;
            zrun_q    <= '0;
            par_odd_q <= 1'b0;
            seen_v_q  <= 1'b0;
        end else begin
            hist_q[0] <= sym_i;
            for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
            if (sym_i == SYM_ZERO) begin
                if (zrun_q <= lim) zrun_q <= zrun_q + ZCNT_W'(1);
            end else begin
                zrun_q <= '0;
            end
            if (sym_i == SYM_BIP) par_odd_q <= ~par_odd_q;
            if (sym_i == SYM_VIOL) begin
                par_odd_q <= 1'b0;
                seen_v_q  <= 1'b1;
            end
        end
    end

    // R3: the run counter never passes one above the zero limit
    p_zrun_cap_r3: assert property (@(posedge clk) disable iff (rst)
        (zrun_q <= lim + ZCNT_W'(1)));

    // R6: a violation pulse restarts the pulse-parity count
    p_parity_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (sym_i == SYM_VIOL) |=> (!par_odd_q && seen_v_q));

endmodule

// File: rtl/bprx_window.sv
`timescale 1ns/1ps
module bprx_window
    import bprx_pkg::*;
#(
    parameter int DEPTH = HD_GRP
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  hdb3_i,
    input  slot_t in_i,
    input  logic  erase_i,
    output slot_t tap_o
);
    localparam int B3_TAP = B3_GRP - 1;
    localparam int HD_TAP = HD_GRP - 1;

    slot_t win [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) win[i] <= '0;
                else     win[i] <= in_i;
            end
        end else begin : g_body
            logic hit;
            assign hit = erase_i &&
                         ((hdb3_i && i == HD_TAP) || (!hdb3_i && i == B3_TAP));
            always_ff @(posedge clk) begin
                if (rst)      win[i] <= '0;
                else if (hit) win[i] <= '{dat: 1'b0, flag: win[i-1].flag};
                else          win[i] <= win[i-1];
            end
        end
    end

    assign tap_o = hdb3_i ? win[HD_TAP] : win[B3_TAP];

    // R8: erased bipolar pulse of a three-symbol group leaves a zero
    p_b3_erase_r8: assert property (@(posedge clk) disable iff (rst)
        (erase_i && !hdb3_i) |=> (win[B3_TAP].dat == 1'b0));

    // R9: erased bipolar pulse of a four-symbol group leaves a zero
    p_hd_erase_r9: assert property (@(posedge clk) disable iff (rst)
        (erase_i && hdb3_i) |=> (win[HD_TAP].dat == 1'b0));

endmodule

// File: rtl/bipolar_rx_decoder.sv
`timescale 1ns/1ps
module bipolar_rx_decoder
    import bprx_pkg::*;
#(
    parameter int ZCNT_W = 3,
    parameter int DEPTH  = HD_GRP
) (
    input  logic clk,
    input  logic rst,
    input  logic rail_p_i,
    input  logic rail_n_i,
    input  logic hdb3_sel_i,
    input  logic bypass_i,
    output logic nrz_o,
    output logic lcv_o
);
    sym_e  sym;
    logic  flag, sub, erase;
    slot_t head, tap;
    logic  byp_p_q, byp_n_q;

    bprx_polarity u_pol (
        .clk   (clk),
        .rst   (rst),
        .pos_i (rail_p_i),
        .neg_i (rail_n_i),
        .sym_o (sym)
    );

    bprx_rules #(.ZCNT_W(ZCNT_W)) u_rules (
        .clk     (clk),
        .rst     (rst),
        .hdb3_i  (hdb3_sel_i),
        .sym_i   (sym),
        .flag_o  (flag),
        .sub_o   (sub),
        .erase_o (erase)
    );

    assign head = '{dat: (sym != SYM_ZERO) && !sub, flag: flag};

    bprx_window #(.DEPTH(DEPTH)) u_win (
        .clk     (clk),
        .rst     (rst),
        .hdb3_i  (hdb3_sel_i),
        .in_i    (head),
        .erase_i (erase),
        .tap_o   (tap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_p_q <= 1'b0;
            byp_n_q <= 1'b0;
        end else begin
            byp_p_q <= rail_p_i;
            byp_n_q <= rail_n_i;
        end
    end

    assign nrz_o = bypass_i ? byp_p_q : tap.dat;
    assign lcv_o = bypass_i ? byp_n_q : tap.flag;

    // R1: bypass passes each rail through one register
    p_bypass_pos_r1: assert property (@(posedge clk) disable iff (rst)
        bypass_i |=> (nrz_o == $past(rail_p_i)));
    p_bypass_neg_r1: assert property (@(posedge clk) disable iff (rst)
        bypass_i |=> (lcv_o == $past(rail_n_i)));

    // R7: dual-rail mark leaves as a flagged one at the mode's tap
    p_dual_b3_r7: assert property (@(posedge clk) disable iff (rst)
        (!bypass_i && !hdb3_sel_i && rail_p_i && rail_n_i) |=> ##2 (nrz_o && lcv_o));
    p_dual_hd_r7: assert property (@(posedge clk) disable iff (rst)
        (!bypass_i && hdb3_sel_i && rail_p_i && rail_n_i) |=> ##3 (nrz_o && lcv_o));

endmodule

// File: tb/sim_bipolar_rx_decoder.sv
`timescale 1ns/1ps
module sim_bipolar_rx_decoder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rail_p = 1'b0, rail_n = 1'b0;
    logic hdb3 = 1'b0, byp = 1'b0;
    logic nrz, lcv;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    bipolar_rx_decoder u0 (
        .clk        (clk),
        .rst        (rst),
        .rail_p_i   (rail_p),
        .rail_n_i   (rail_n),
        .hdb3_sel_i (hdb3),
        .bypass_i   (byp),
        .nrz_o      (nrz),
        .lcv_o      (lcv)
    );

    // Reference model state (behavioural)
    int   idx;
    int   cls   [0:4095];
    logic exp_d [0:4095];
    logic exp_f [0:4095];
    logic m_seen, m_lastneg, m_seenv;
    int   m_run, m_bcnt;

    task automatic check(input string tag, input logic ad, input logic af,
                         input logic ed, input logic ef);
        checks++;
        if (ad !== ed || af !== ef) begin
            failures++;
            $display("FAIL %s idx=%0d nrz=%b lcv=%b expected nrz=%b lcv=%b",
                     tag, idx, ad, af, ed, ef);
        end
    endtask

    // R10: reset clears outputs and history
    task automatic do_reset(input logic mode, input logic bp);
        @(negedge clk);
        rst = 1'b1; hdb3 = mode; byp = bp; rail_p = 1'b0; rail_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", nrz, lcv, 1'b0, 1'b0);
        rst = 1'b0;
        idx = 0; m_seen = 0; m_lastneg = 0; m_seenv = 0; m_run = 0; m_bcnt = 0;
    endtask

    // Drive one symbol at a falling edge; check after the following rising edge
    task automatic step(input string tag, input logic p, input logic n);
        int c, h0, h1, lim, tap, old;
        logic f, sub;
        if (p && n) c = 3;
        else if (p || n) begin
            c = (!m_seen || n != m_lastneg) ? 1 : 2;
            m_seen = 1; m_lastneg = n;
        end else c = 0;
        cls[idx] = c;
        h0 = (idx >= 1) ? cls[idx-1] : 0;
        h1 = (idx >= 2) ? cls[idx-2] : 0;
        lim = hdb3 ? 3 : 2;
        f = 0;
        if (c == 0) begin
            m_run++;
            if (m_run == lim + 1) f = 1;            // R3
        end else m_run = 0;
        if (c == 2 && (h0 == 1 || (hdb3 && h0 == 0 && h1 == 1))) f = 1; // R4 R5
        if (c == 2 && m_seenv && (m_bcnt % 2 == 0)) f = 1;              // R6
        if (c == 3) f = 1;                                               // R7
        if (c == 1) m_bcnt++;
        if (c == 2) begin m_bcnt = 0; m_seenv = 1; end
        sub = (c == 2) && (h0 == 0) && (!hdb3 || h1 == 0);               // R8 R9
        if (sub) begin
            old = idx - (hdb3 ? 3 : 2);
            if (old >= 0 && cls[old] == 1) exp_d[old] = 0;
        end
        exp_d[idx] = (c != 0) && !sub;
        exp_f[idx] = f;
        rail_p = p; rail_n = n;
        @(posedge clk);
        @(negedge clk);
        if (byp) check(tag, nrz, lcv, p, n);                              // R1
        else begin
            tap = hdb3 ? 3 : 2;                                           // R2 R12
            if (idx >= tap) check(tag, nrz, lcv, exp_d[idx-tap], exp_f[idx-tap]);
            else            check(tag, nrz, lcv, 1'b0, 1'b0);
        end
        idx++;
    endtask

    task automatic play(input string tag, input string s);
        for (int i = 0; i < s.len(); i++) begin
            byte ch;
            ch = s[i];
            step(tag, (ch == "+" || ch == "X"), (ch == "-" || ch == "X"));
        end
    endtask

    task automatic play_random(input string tag, input int n, input int seed);
        logic [15:0] lf;
        lf = 16'hACE1 ^ 16'(seed);
        for (int i = 0; i < n; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[2:0])
                3'd0, 3'd1, 3'd2: step(tag, 1'b0, 1'b0);
                3'd3, 3'd4:       step(tag, 1'b1, 1'b0);
                3'd5, 3'd6:       step(tag, 1'b0, 1'b1);
                default:          step(tag, lf[5], lf[6] | ~lf[5]);
            endcase
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired idx=%0d expected completion", idx);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // three-symbol-group mode
        do_reset(1'b0, 1'b0);
        play("R11", "-0+");
        play("R2", "-+-0+0-+-");
        play("R8", "+-0-+00+-+0+0");
        play("R3", "+000-00+0");
        play("R4", "+--+");
        play("R6", "-0-+-+0+-0-");
        play("R7", "+X-0X00");
        play("R2", "0000");
        play_random("R12", 600, 7);

        // four-symbol-group mode
        do_reset(1'b1, 1'b0);
        play("R11", "+");
        play("R9", "-+00+-000-+00+");
        play("R5", "-0-+0+");
        play("R3", "+000-0000+");
        play("R4", "-++");
        play("R6", "-00-+-+00+");
        play("R7", "X0+X000");
        play_random("R12", 600, 11);

        // bypass
        do_reset(1'b0, 1'b1);
        play("R1", "+-X0-+00X");
        do_reset(1'b1, 1'b1);
        play_random("R1", 100, 3);

        do_reset(1'b0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule